// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Controller

This block collects fifteen interrupt request lines, numbered 1 to 15, and tells processor 0 which one to service next. A rising edge on a line latches it as pending. If the line is selected for broadcast, the edge goes instead into the software force register of every processor. Software can also force lines directly, clear them, give each line high or low priority, and gate delivery with a per-processor mask. Per-processor mask, force and 4-bit extended registers exist for up to sixteen processors. Only processor 0 is given a delivery output.

Software reaches the block through a 256-byte window of 32-bit words. Reads are registered, and read data appears one cycle after the read strobe. Processor 0 sees a registered 4-bit interrupt number, where 0 means nothing is to be taken. When the processor takes an interrupt, it returns the number on a one-cycle acknowledge strobe, and that interrupt is removed from both pending and its force register.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every register reads 0 and `cpu0_irq` is 0.
- R2: A 0-to-1 transition on `irq_lines[n]` (n in 1..15) sets bit n of the pending word (read at 0x04) when broadcast bit n is 0. A line held high does not set the bit again after it has been cleared.
- R3: A rising line whose broadcast bit (word 0x14, bit n) is 1 sets bit n in the force word of every processor and leaves pending unchanged.
- R4: The candidates are (pending | force0) & mask0, with mask0 at 0x40. If any candidate has its priority bit (word 0x00, bit n) at 1, `cpu0_irq` gives the highest-numbered such candidate. Otherwise it gives the highest-numbered remaining candidate, or 0 if there is none. The output follows a state change by one clock.
- R5: Writing force word k at 0x80+4k sets the bits of wdata[15:1] and clears the bits of wdata[31:17] in one write. The force word reads back at the same address.
- R6: Writing 0x08 replaces force0 with wdata[15:1]. Reading 0x08 returns force0.
- R7: Writing 0x0C clears the written bits in both pending and force0.
- R8: `ack_valid` with `ack_num`=n clears bit n of pending and of force0. When it coincides with a register write, the write is applied first and the acknowledge clear second.
- R9: Writes to 0x04 and 0x10 are ignored. Reads of 0x0C and 0x10 return 0.
- R10: Extended word k at 0xC0+4k stores only wdata[3:0] and has no effect on `cpu0_irq`.
- R11: Bit 0 is dropped on writes to the priority, force, clear, broadcast and mask words, so it always reads back as 0.
- R12: Reads of unmapped word offsets (0x18 to 0x3C) return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_lines | input | 16 | Interrupt request lines (bit 0 unused) |
| ack_valid | input | 1 | Acknowledge strobe from processor 0 |
| ack_num | input | 4 | Number of the interrupt being acknowledged |
| cpu0_irq | output | 4 | Interrupt number for processor 0, 0 for none |

## Verification
Some properties are checked on every cycle. The delivered number must be nonzero exactly when the previous cycle had a candidate. It must come from the high-priority group whenever that group was non-empty. An acknowledged bit must be absent from pending and force0 afterwards. The clear and status words must read 0. The bench scenarios cover the rest: edge-only latching with a held line, broadcast fan-out into several force words, set-and-clear in one force write, the alias overwrite, the write-then-acknowledge ordering, and the zeroing of unmapped and bit-0 accesses.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int WORD_W  = 32;
  localparam int LINES   = 16;
  localparam int NUM_W   = $clog2(LINES);
  localparam logic [LINES-1:0] KEEP = {{(LINES-1){1'b1}}, 1'b0};

  // global word indices (byte offset / 4) within the first 64 bytes
  localparam logic [3:0] G_PRIO  = 4'd0;
  localparam logic [3:0] G_PEND  = 4'd1;
  localparam logic [3:0] G_FALI  = 4'd2;
  localparam logic [3:0] G_CLR   = 4'd3;
  localparam logic [3:0] G_MPST  = 4'd4;
  localparam logic [3:0] G_BCAST = 4'd5;

  typedef enum logic [1:0] {
    RG_GLOBAL = 2'd0,
    RG_MASK   = 2'd1,
    RG_FORCE  = 2'd2,
    RG_EXT    = 2'd3
  } region_e;

  function automatic logic [NUM_W-1:0] top_bit(input logic [LINES-1:0] v);
    logic [NUM_W-1:0] r;
    r = '0;
    for (int i = 1; i < LINES; i++)
      if (v[i]) r = NUM_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/irq_bank.sv
module irq_bank
  import irq_prio_pkg::*;
#(
  parameter int NCPU = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata_o,
  input  logic [LINES-1:0]  line_in,
  input  logic              ack_valid,
  input  logic [NUM_W-1:0]  ack_num,
  output logic [LINES-1:0]  pend_o,
  output logic [LINES-1:0]  force0_o,
  output logic [LINES-1:0]  mask0_o,
  output logic [LINES-1:0]  prio_o
);
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1;

  logic [LINES-1:0] prio_q, pend_q, bcast_q, line_q;
  logic [LINES-1:0] prio_n, pend_n, bcast_n;
  logic [LINES-1:0] msk_q [NCPU];
  logic [LINES-1:0] frc_q [NCPU];
  logic [3:0]       ext_q [NCPU];
  logic [LINES-1:0] msk_n [NCPU];
  logic [LINES-1:0] frc_n [NCPU];
  logic [3:0]       ext_n [NCPU];

  region_e          region;
  logic [3:0]       slot;
  logic             slot_ok;
  logic [CPU_W-1:0] cpu;
  logic [LINES-1:0] set_bits, clr_bits, rise;
  logic [WORD_W-1:0] rd_val;
  logic             unused_addr;

  assign region      = region_e'(addr[7:6]);
  assign slot        = addr[5:2];
  assign slot_ok     = ({1'b0, slot} < 5'(NCPU));
  assign cpu         = slot[CPU_W-1:0];
  assign set_bits    = wdata[LINES-1:0] & KEEP;
  assign clr_bits    = wdata[WORD_W-1:WORD_W-LINES] & KEEP;
  assign rise        = line_in & ~line_q & KEEP;
  assign unused_addr = ^addr[1:0];

  always_comb begin
    prio_n  = prio_q;
    pend_n  = pend_q;
    bcast_n = bcast_q;
    msk_n   = msk_q;
    frc_n   = frc_q;
    ext_n   = ext_q;
    // software writes first
    if (wr_en) begin
      unique case (region)
        RG_GLOBAL: begin
          case (slot)
            G_PRIO:  prio_n   = set_bits;
            G_FALI:  frc_n[0] = set_bits;
            G_CLR: begin
              pend_n   = pend_n & ~set_bits;
              frc_n[0] = frc_n[0] & ~set_bits;
            end
            G_BCAST: bcast_n  = set_bits;
            default: ;
          endcase
        end
        RG_MASK:  if (slot_ok) msk_n[cpu] = set_bits;
        RG_FORCE: if (slot_ok) frc_n[cpu] = (frc_q[cpu] | set_bits) & ~clr_bits;
        RG_EXT:   if (slot_ok) ext_n[cpu] = wdata[3:0];
      endcase
    end
    // then line edges
    pend_n = pend_n | (rise & ~bcast_q);
    for (int c = 0; c < NCPU; c++)
      frc_n[c] = frc_n[c] | (rise & bcast_q);
    // acknowledge last
    if (ack_valid) begin
      pend_n[ack_num]   = 1'b0;
      frc_n[0][ack_num] = 1'b0;
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (region)
      RG_GLOBAL: begin
        case (slot)
          G_PRIO:  rd_val[LINES-1:0] = prio_q;
          G_PEND:  rd_val[LINES-1:0] = pend_q;
          G_FALI:  rd_val[LINES-1:0] = frc_q[0];
          G_BCAST: rd_val[LINES-1:0] = bcast_q;
          default: rd_val = '0;
        endcase
      end
      RG_MASK:  if (slot_ok) rd_val[LINES-1:0] = msk_q[cpu];
      RG_FORCE: if (slot_ok) rd_val[LINES-1:0] = frc_q[cpu];
      RG_EXT:   if (slot_ok) rd_val[3:0] = ext_q[cpu];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q  <= '0;
      pend_q  <= '0;
      bcast_q <= '0;
      line_q  <= '0;
      rdata_o <= '0;
      for (int c = 0; c < NCPU; c++) begin
        msk_q[c] <= '0;
        frc_q[c] <= '0;
        ext_q[c] <= '0;
      end
    end else begin
      prio_q  <= prio_n;
      pend_q  <= pend_n;
      bcast_q <= bcast_n;
      line_q  <= line_in;
      rdata_o <= rd_en ? rd_val : '0;
      for (int c = 0; c < NCPU; c++) begin
        msk_q[c] <= msk_n[c];
        frc_q[c] <= frc_n[c];
        ext_q[c] <= ext_n[c];
      end
    end
  end

  assign pend_o   = pend_q;
  assign force0_o = frc_q[0];
  assign mask0_o  = msk_q[0];
  assign prio_o   = prio_q;

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    ack_valid |=> (pend_q[$past(ack_num)] == 1'b0) && (frc_q[0][$past(ack_num)] == 1'b0));

  // R9
  zero_words_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && (addr == 8'h0C || addr == 8'h10) |=> rdata_o == '0);
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] pend,
  input  logic [LINES-1:0] force0,
  input  logic [LINES-1:0] mask0,
  input  logic [LINES-1:0] prio,
  output logic [NUM_W-1:0] irq_num_o
);
  logic [LINES-1:0] cand, hi_grp, lo_grp, chosen;

  assign cand   = (pend | force0) & mask0;
  assign hi_grp = cand & prio;
  assign lo_grp = cand & ~prio;
  assign chosen = (|hi_grp) ? hi_grp : lo_grp;

  always_ff @(posedge clk) begin
    if (rst) irq_num_o <= '0;
    else     irq_num_o <= top_bit(chosen);
  end

  // R4
  num_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((irq_num_o != '0) == $past(|(cand & KEEP))));

  // R4
  high_first_chk: assert property (@(posedge clk) disable iff (rst)
    (|(cand & prio & KEEP)) |=> $past(prio[irq_num_o]) || prio[irq_num_o]);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NCPU = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [15:0] irq_lines,
  input  logic        ack_valid,
  input  logic [3:0]  ack_num,
  output logic [3:0]  cpu0_irq
);
  logic [LINES-1:0] pend, force0, mask0, prio;

  irq_bank #(.NCPU(NCPU)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata_o(bus_rdata),
    .line_in(irq_lines), .ack_valid(ack_valid), .ack_num(ack_num),
    .pend_o(pend), .force0_o(force0), .mask0_o(mask0), .prio_o(prio)
  );

  irq_pick u_pick (
    .clk(clk), .rst(rst),
    .pend(pend), .force0(force0), .mask0(mask0), .prio(prio),
    .irq_num_o(cpu0_irq)
  );
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_lines = '0;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_num = '0;
  logic [3:0]  cpu0_irq;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        mon_rd = 1'b0;

  always #10 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .ack_valid(ack_valid), .ack_num(ack_num),
    .cpu0_irq(cpu0_irq)
  );

  // monitor: compares registered read data with the queued expectation
  always @(posedge clk) mon_rd <= bus_rd;
  always @(negedge clk) begin
    if (mon_rd && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic wr_ack(input logic [7:0] a, input logic [31:0] d, input logic [3:0] n);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    ack_valid = 1'b1; ack_num = n;
    @(negedge clk); bus_wr = 1'b0; ack_valid = 1'b0;
  endtask

  task automatic ack(input logic [3:0] n);
    @(negedge clk); ack_valid = 1'b1; ack_num = n;
    @(negedge clk); ack_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic lines(input logic [15:0] v);
    @(negedge clk); irq_lines = v;
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic [3:0] e, input string t);
    @(negedge clk);
    checks++;
    if (cpu0_irq !== e) begin
      errors++;
      $display("FAIL %s: cpu0_irq actual %0d expected %0d", t, cpu0_irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_irq(4'd0, "R1");
    rd(8'h00, 32'h0, "R1 prio");
    rd(8'h04, 32'h0, "R1 pend");
    rd(8'h14, 32'h0, "R1 bcast");
    rd(8'h40, 32'h0, "R1 mask0");
    // R2 edge latch; R11 mask bit0
    lines(16'h0020);
    rd(8'h04, 32'h0000_0020, "R2 pend");
    chk_irq(4'd0, "R4 masked");
    wr(8'h40, 32'h0000_FFFF);
    chk_irq(4'd5, "R4 line5");
    rd(8'h40, 32'h0000_FFFE, "R11 mask bit0");
    // R7 clear while line held; R2 no re-latch
    wr(8'h0C, 32'h0000_0020);
    chk_irq(4'd0, "R7 cleared");
    rd(8'h04, 32'h0, "R2 held line");
    lines(16'h0000);
    // R4 priority groups
    lines(16'h0208);
    chk_irq(4'd9, "R4 low group top");
    wr(8'h00, 32'h0000_0009);
    chk_irq(4'd3, "R4 high group wins");
    rd(8'h00, 32'h0000_0008, "R11 prio bit0");
    lines(16'h0000);
    // R8 acknowledge, then with a coincident write
    ack(4'd3);
    chk_irq(4'd9, "R8 ack 3");
    rd(8'h04, 32'h0000_0200, "R8 pend");
    wr_ack(8'h08, 32'h0000_0202, 4'd9);
    chk_irq(4'd1, "R8 write then ack");
    rd(8'h08, 32'h0000_0002, "R8 force0");
    rd(8'h04, 32'h0, "R8 pend cleared");
    // R5 set and clear in one force write
    wr(8'h80, 32'h0002_4010);
    chk_irq(4'd14, "R5 force0");
    rd(8'h80, 32'h0000_4010, "R5 force0 read");
    rd(8'h08, 32'h0000_4010, "R6 alias read");
    wr(8'h8C, 32'h0000_0006);
    rd(8'h8C, 32'h0000_0006, "R5 force3");
    chk_irq(4'd14, "R5 force3 no effect");
    // R6 alias overwrite
    wr(8'h08, 32'h0000_0101);
    chk_irq(4'd8, "R6 overwrite");
    rd(8'h08, 32'h0000_0100, "R6 alias value");
    // R9 read-only and zero words
    wr(8'h04, 32'h0000_FFFF);
    rd(8'h04, 32'h0, "R9 pend write ignored");
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0, "R9 status");
    rd(8'h0C, 32'h0, "R9 clear reads 0");
    // R3 broadcast
    wr(8'h14, 32'h0000_0041);
    rd(8'h14, 32'h0000_0040, "R11 bcast bit0");
    lines(16'h0040);
    rd(8'h04, 32'h0, "R3 pend untouched");
    rd(8'h80, 32'h0000_0140, "R3 force0");
    rd(8'h8C, 32'h0000_0046, "R3 force3");
    rd(8'hBC, 32'h0000_0040, "R3 force15");
    chk_irq(4'd8, "R3 delivery");
    wr(8'h0C, 32'h0000_0140);
    chk_irq(4'd0, "R7 force0 cleared");
    rd(8'h08, 32'h0, "R7 force0 read");
    lines(16'h0000);
    // R10 extended
    wr(8'hC4, 32'hFFFF_FFFF);
    rd(8'hC4, 32'h0000_000F, "R10 ext");
    chk_irq(4'd0, "R10 no delivery");
    // R12 unmapped
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0, "R12 unmapped read");
    rd(8'h18, 32'h0, "R12 unmapped read 18");
    rd(8'h00, 32'h0000_0008, "R12 prio untouched");
    chk_irq(4'd0, "R12 no delivery");
    // R4 mask gating of a forced line
    wr(8'h40, 32'h0);
    wr(8'h08, 32'h0000_8000);
    chk_irq(4'd0, "R4 masked force");
    wr(8'h40, 32'h0000_8000);
    chk_irq(4'd15, "R4 unmasked 15");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule